// File: doc/BRIEF.md
# Configurable LUT logic cell

This block is one programmable logic cell meant to be tiled across a reconfigurable fabric. A 16-entry truth table is held as two 8-entry halves. Both halves are addressed by the same three low logic inputs. In normal mode the fourth input picks one half, so the pair acts as a single 4-input lookup table. In arithmetic mode the two half outputs become the operands of a one-bit full adder. The adder takes its carry from the neighbouring cell and passes a carry on to the next one, and its sum becomes the cell result.

A D flip-flop with a clock enable can hold the result. A configuration bit chooses whether the output pin shows the registered value or the combinational result. The 18 configuration bits are loaded through a serial chain whenever the configuration enable is high. The chain's far end is brought out so that many cells can be daisy-chained.

Top module: `lut_cell`

## Requirements
- R1: The configuration is an 18-bit word: bits 15:0 are the truth table (bits 7:0 are the low half, bits 15:8 the high half), bit 16 is the mode (0 normal, 1 arithmetic) and bit 17 is the output select (0 combinational, 1 registered). While `cfg_en` is high, each rising edge shifts `cfg_din` in at bit 17 and moves every bit down one place, so a word sent least significant bit first is complete after 18 edges. `cfg_sout` always shows bit 0, which is the bit that leaves the chain on the next shift. While `cfg_en` is low the word does not change.
- R2: In normal mode with combinational output, `dout` equals truth-table bit `lut_in`, where `lut_in` bit 0 is input a and bit 3 is input d.
- R3: In arithmetic mode, lo = table bit `lut_in[2:0]` and hi = table bit 8+`lut_in[2:0]`. The result is lo XOR hi XOR `carry_in`, and `lut_in[3]` has no effect.
- R4: In arithmetic mode `carry_out` is the majority of lo, hi and `carry_in`. In normal mode `carry_out` is 0.
- R5: With output select 1, `dout` shows the flip-flop. The flip-flop takes the cell result on a rising edge when `ce` is 1 and `cfg_en` is 0, so `dout` lags the combinational result by one cycle.
- R6: When `ce` is 0 the flip-flop keeps its value.
- R7: While `cfg_en` is high the flip-flop keeps its value, even when `ce` is 1.
- R8: When `rst_n` is low at a rising edge, the flip-flop is cleared to 0. Reset does not change the configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flip-flop |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Serial configuration data out (bit 0 of the word) |
| ce | input | 1 | Flip-flop clock enable |
| lut_in | input | 4 | Logic inputs; bit 0 is a, bit 3 is d |
| carry_in | input | 1 | Carry from the neighbouring cell |
| carry_out | output | 1 | Carry to the next cell |
| dout | output | 1 | Cell output |

## Verification
The assertions assume that the configuration word is fully loaded before the result or carry is used. They also assume that the output select stays fixed whenever `cfg_en` is low, because the registered-path check compares the output with the result one cycle earlier. The stimulus follows both rules. It always finishes an 18-bit load before it changes logic inputs or looks at outputs, and it only changes the word through `cfg_en`. Every configuration is swept over all 16 input values and both carry values in each mode, and the expected results are worked out from the truth-table bits in the bench.

// File: rtl/lcell_pkg.sv
`timescale 1ns/1ps
// Package lcell_pkg: shared sizing and the carry helper for the logic cell.
// Assumes a cell built from two equal lookup halves.
package lcell_pkg;
    localparam int DEF_HALF_K = 3;

    // Majority of three bits, used for the carry of a full adder.
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (z & (x ^ y));
    endfunction
endpackage

// File: rtl/lcell_cfg_chain.sv
`timescale 1ns/1ps
// Module lcell_cfg_chain: serial configuration store. A bit enters at the top
// and the whole word moves down one place per enabled edge. Reset does not
// touch it. Assumes the word is sent least significant bit first.
module lcell_cfg_chain #(
    parameter int CFG_BITS = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                cfg_din,
    output logic [CFG_BITS-1:0] cfg_q,
    output logic                cfg_sout
);
    logic [CFG_BITS-1:0] chain_r;

    // Shift one configuration bit in per enabled edge.
    always_ff @(posedge clk) begin
        if (cfg_en) chain_r <= {cfg_din, chain_r[CFG_BITS-1:1]};
    end

    assign cfg_q    = chain_r;
    assign cfg_sout = chain_r[0];

    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> cfg_q[CFG_BITS-1] == $past(cfg_din));
    assert_word_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q));
endmodule

// File: rtl/lcell_lut_half.sv
`timescale 1ns/1ps
// Module lcell_lut_half: one K-input lookup half. The select value is the
// table index, with select bit 0 as the least significant bit.
module lcell_lut_half #(
    parameter int K = 3,
    localparam int ENTRIES = 1 << K
) (
    input  logic [ENTRIES-1:0] table_bits,
    input  logic [K-1:0]       sel,
    output logic               y
);
    // Read the addressed truth-table entry.
    always_comb y = table_bits[sel];
endmodule

// File: rtl/lcell_arith.sv
`timescale 1ns/1ps
// Module lcell_arith: combines the two half outputs. In normal mode it is a
// 2:1 mux steered by the top input; in arithmetic mode it is a full adder.
// Carry out is held at 0 in normal mode so an idle chain stays quiet.
module lcell_arith (
    input  logic lo,
    input  logic hi,
    input  logic top_sel,
    input  logic arith_mode,
    input  logic cin,
    output logic result,
    output logic cout
);
    logic merged;
    logic sum;

    // Merge the halves into one wider table, or add them.
    always_comb begin
        merged = top_sel ? hi : lo;
        sum    = lo ^ hi ^ cin;
        result = arith_mode ? sum : merged;
        cout   = arith_mode ? lcell_pkg::maj3(lo, hi, cin) : 1'b0;
    end
endmodule

// File: rtl/lcell_out_reg.sv
`timescale 1ns/1ps
// Module lcell_out_reg: the cell flip-flop, with a synchronous active-low
// clear and a clock enable. It holds its value while the configuration shifts.
module lcell_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic ce,
    input  logic d,
    output logic q
);
    // Capture the cell result when enabled and not configuring.
    always_ff @(posedge clk) begin
        if (!rst_n)              q <= 1'b0;
        else if (ce && !cfg_en)  q <= d;
    end

    assert_clear_R8: assert property (@(posedge clk)
        !rst_n |=> q == 1'b0);
    assert_hold_no_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(q));
    assert_hold_in_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> $stable(q));
endmodule

// File: rtl/lut_cell.sv
`timescale 1ns/1ps
// Module lut_cell: a configurable logic cell made of two lookup halves, a
// mode mux and full adder, a flip-flop and an output-select mux. The
// configuration word is {out_sel, mode, table}. It assumes the word is fully
// loaded before the outputs are used.
module lut_cell #(
    parameter int HALF_K = lcell_pkg::DEF_HALF_K,
    localparam int HALF_BITS = 1 << HALF_K,
    localparam int TT_BITS   = 2 * HALF_BITS,
    localparam int CFG_BITS  = TT_BITS + 2,
    localparam int MODE_POS  = TT_BITS,
    localparam int OSEL_POS  = TT_BITS + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_din,
    output logic            cfg_sout,
    input  logic            ce,
    input  logic [HALF_K:0] lut_in,
    input  logic            carry_in,
    output logic            carry_out,
    output logic            dout
);
    logic [CFG_BITS-1:0] cfg_word;
    logic [1:0]          half_y;
    logic                cell_result;
    logic                ff_q;

    lcell_cfg_chain #(.CFG_BITS(CFG_BITS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_q(cfg_word), .cfg_sout(cfg_sout)
    );

    for (genvar g = 0; g < 2; g++) begin : g_half
        lcell_lut_half #(.K(HALF_K)) u_half (
            .table_bits(cfg_word[g*HALF_BITS +: HALF_BITS]),
            .sel(lut_in[HALF_K-1:0]),
            .y(half_y[g])
        );
    end

    lcell_arith u_arith (
        .lo(half_y[0]), .hi(half_y[1]), .top_sel(lut_in[HALF_K]),
        .arith_mode(cfg_word[MODE_POS]), .cin(carry_in),
        .result(cell_result), .cout(carry_out)
    );

    lcell_out_reg u_reg (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ce(ce),
        .d(cell_result), .q(ff_q)
    );

    // Choose the registered or the combinational result for the output pin.
    always_comb dout = cfg_word[OSEL_POS] ? ff_q : cell_result;

    assert_no_carry_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !cfg_word[MODE_POS]) |-> carry_out == 1'b0);
    assert_reg_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && ce && cfg_word[OSEL_POS]) ##1 !cfg_en |-> dout == $past(cell_result));
endmodule

// File: tb/lut_cell_tb.sv
`timescale 1ns/1ps
// Bench lut_cell_tb: loads random truth tables and sweeps every input value
// and carry value in both modes. It then checks the registered path,
// clock-enable hold, hold during configuration and reset.
module lut_cell_tb;
    logic       clk = 1'b0;
    logic       rst_n, cfg_en, cfg_din, ce, carry_in;
    logic [3:0] lut_in;
    logic       cfg_sout, carry_out, dout;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;
    logic [17:0] cur_cfg;
    logic        prev_q;

    always #10 clk = ~clk;

    lut_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_sout(cfg_sout), .ce(ce), .lut_in(lut_in), .carry_in(carry_in),
        .carry_out(carry_out), .dout(dout)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b cfg=%h in=%h cin=%0b",
                     req, act, exp, cur_cfg, lut_in, carry_in);
        end
    endtask

    // Expected result from the requirement text.
    function automatic logic exp_res(input logic [17:0] c, input logic [3:0] x, input logic ci);
        logic lo, hi;
        lo = c[{1'b0, x[2:0]}];
        hi = c[{1'b1, x[2:0]}];
        if (c[16]) return lo ^ hi ^ ci;
        return c[x];
    endfunction

    function automatic logic exp_cout(input logic [17:0] c, input logic [3:0] x, input logic ci);
        logic lo, hi;
        lo = c[{1'b0, x[2:0]}];
        hi = c[{1'b1, x[2:0]}];
        if (!c[16]) return 1'b0;
        return (lo + hi + ci) >= 2;
    endfunction

    // Shift a word in LSB first; the old word must come out of cfg_sout (R1).
    task automatic load(input logic [17:0] w, input bit chk_out);
        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = w[i];
            #1;
            if (chk_out) check("R1 serial out", cfg_sout, cur_cfg[i]);
            @(posedge clk);
        end
        @(negedge clk);
        cfg_en  = 1'b0;
        cur_cfg = w;
    endtask

    initial begin
        rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; ce = 1'b0;
        carry_in = 1'b0; lut_in = 4'h0; cur_cfg = '0; prev_q = 1'b0;
        repeat (2) @(negedge clk);
        load({2'b11, 16'h0000}, 0);
        rst_n = 1'b1;
        #2 check("R8 reset state", dout, 1'b0);

        for (int k = 0; k < 24; k++) begin
            logic [15:0] tt;
            tt = 16'($urandom);
            if (k == 0) tt = 16'hFFFF;
            if (k == 1) tt = 16'h00FF;

            // R2: normal mode, combinational output.
            load({2'b00, tt}, 1);
            for (int v = 0; v < 32; v++) begin
                lut_in = v[3:0]; carry_in = v[4];
                #2;
                check("R2 normal result", dout, tt[v[3:0]]);
                check("R4 normal carry", carry_out, 1'b0);
            end

            // R3/R4: arithmetic mode, combinational output.
            load({2'b01, tt}, 1);
            for (int v = 0; v < 32; v++) begin
                lut_in = v[3:0]; carry_in = v[4];
                #2;
                check("R3 arith sum", dout, exp_res(cur_cfg, lut_in, carry_in));
                check("R4 arith carry", carry_out, exp_cout(cur_cfg, lut_in, carry_in));
            end

            // R5: registered output, one-cycle latency.
            load({1'b1, k[0], tt}, 1);
            prev_q = dout;
            for (int v = 0; v < 16; v++) begin
                @(negedge clk);
                lut_in = v[3:0]; carry_in = v[0] ^ k[1]; ce = 1'b1;
                #2 check("R5 before edge", dout, prev_q);
                @(posedge clk);
                #2 check("R5 after edge", dout, exp_res(cur_cfg, lut_in, carry_in));
                prev_q = exp_res(cur_cfg, lut_in, carry_in);
            end

            // R6: clock enable low holds.
            @(negedge clk);
            ce = 1'b0; lut_in = ~lut_in; carry_in = ~carry_in;
            @(posedge clk);
            #2 check("R6 ce hold", dout, prev_q);

            // R7: flip-flop holds during configuration even with ce high.
            ce = 1'b1;
            load({2'b11, ~tt}, 1);
            #2 check("R7 cfg hold", dout, prev_q);

            // R8: reset clears the flip-flop and keeps the configuration.
            if (k % 6 == 5) begin
                @(negedge clk);
                rst_n = 1'b0;
                @(posedge clk);
                #2 check("R8 reset clear", dout, 1'b0);
                @(negedge clk);
                rst_n = 1'b1; lut_in = 4'h3; carry_in = 1'b1;
                @(posedge clk);
                #2 check("R8 config kept", dout, exp_res(cur_cfg, lut_in, carry_in));
            end
            @(negedge clk);
            ce = 1'b0;
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule